// File: doc/BRIEF.md
# I2C Master Bus Condition Sequencer

This block puts START, repeated START and STOP conditions on an open-drain two-wire bus. Software asks for them through two request bits: a start request and a stop request. The block pulls SCL and SDA low through active-high output-enable signals and reads both lines back. It watches every START and STOP on the bus, so it knows when another master holds the bus. It then queues its own START until the bus is released.

A prescaler sets the bus timing. One half-period of SCL equals `HALF_DIV` clock cycles. The shift engine reports each finished byte on `byte_done`, which makes a repeated START possible. A serial-interrupt flag `si` holds SCL low while the master phase waits for software. An enable input turns the block off and drops every bus drive. Byte shifting, arbitration and status codes belong to neighbouring blocks.

Top module: `bus_cond_seq`

## Requirements
- R1: With `sta_bit` set, `enable` high and the bus free, `sda_oe` rises while `scl_oe` is 0, at most H+2 cycles after the request (H = `HALF_DIV`). `scl_oe` rises H cycles later. At that point `master` is 1 and `sta_bit` has been cleared.
- R2: If the bus is busy when the start request arrives, neither line is driven until a STOP is seen. The START (`sda_oe` rising with `scl_oe` at 0) then follows no sooner than H cycles after the STOP.
- R3: While master, a start request does nothing until `byte_done` has pulsed. After that, the block releases SDA, then releases SCL, then pulls SDA with SCL high, then pulls SCL, with H cycles between steps. The repeated START clears `sta_bit`.
- R4: A stop request while master releases SCL while SDA stays pulled, then releases SDA H cycles later. `sto_bit` and `master` fall one cycle after the STOP is seen on the lines.
- R5: With both request bits set while master, the block sends a STOP and then, after a gap of at least H cycles, a START.
- R6: A stop request while not master drives neither line. `sto_bit` reads 1 for exactly one cycle and then clears itself.
- R7: While `enable` is 0, `scl_oe`, `sda_oe`, `master` and `sto_bit` are 0 and line activity does not set `bus_busy`. Reset leaves all outputs at 0.
- R8: While `si` is 1, a low SCL phase driven by the block is held. The phase ends H cycles after `si` falls. A released (high) SCL phase is not lengthened by `si`.
- R9: `bus_busy` goes to 1 one cycle after SDA falls while SCL is high, including a START made by the block itself. It goes to 0 one cycle after SDA rises while SCL is high.
- R10: The count of a released SCL phase starts only once `scl_i` reads high. If another device holds SCL low, the SDA release of a STOP comes H cycles after SCL actually rises.
- R11: Clearing `sta_bit` with `sta_clr` while a START is queued cancels it. Nothing is driven after the bus is freed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| enable | input | 1 | Block enable; 0 releases the bus and clears the stop request |
| sta_set | input | 1 | One-cycle pulse that sets the start request bit |
| sta_clr | input | 1 | One-cycle pulse that clears the start request bit (wins over set) |
| sto_set | input | 1 | One-cycle pulse that sets the stop request bit |
| byte_done | input | 1 | Pulse from the shift engine when a byte has been transferred |
| si | input | 1 | Serial-interrupt flag; holds a driven-low SCL phase |
| scl_i | input | 1 | SCL line level, already synchronised to clk |
| sda_i | input | 1 | SDA line level, already synchronised to clk |
| scl_oe | output | 1 | 1 pulls SCL low |
| sda_oe | output | 1 | 1 pulls SDA low |
| sta_bit | output | 1 | Start request bit as seen by software |
| sto_bit | output | 1 | Stop request bit as seen by software |
| bus_busy | output | 1 | A START has been seen and no STOP since |
| master | output | 1 | The block currently owns the bus |

## Verification
The bench models the open-drain wires itself and plays the other master and a stretching slave. It measures, in cycles, every gap between line edges and compares each gap with a window derived from H. A queued START that ignored the STOP would show up as SDA being pulled during the quiet window. A missing bus-free gap would show up as an early START, and a repeated START issued without a finished byte would drop SDA while the bench expects it held. A design that let `si` stretch the high phase would lengthen the STOP's SCL-high time. One that timed the high phase from its own release instead of the line level would let SDA go too early under a slave stretch, and the bench sweeps that stretch over several lengths.

// File: rtl/bcs_pkg.sv
// Shared types for the bus condition sequencer.
package bcs_pkg;

    // Sequencer states. The comments give the line drive as SCL/SDA
    // (L = pulled low, R = released).
    typedef enum logic [3:0] {
        S_IDLE    = 4'd0,  // R/R, no bus ownership
        S_QUEUE   = 4'd1,  // R/R, start pending, bus owned by someone else
        S_GAP     = 4'd2,  // R/R, bus free time before a start
        S_STA_HI  = 4'd3,  // R/L, start condition: SDA low with SCL high
        S_HOLD    = 4'd4,  // L/L, master phase, SCL held low
        S_STP_SCL = 4'd5,  // R/L, stop step 1: SCL high, SDA still low
        S_STP_SDA = 4'd6,  // R/R, stop step 2: wait for the stop on the lines
        S_RS_SDA  = 4'd7,  // L/R, repeated start step 1: SDA released
        S_RS_SCL  = 4'd8   // R/R, repeated start step 2: SCL released
    } seq_state_e;

endpackage

// File: rtl/bcs_tick.sv
// Half-period timer for the bus condition sequencer.
// It counts clock cycles and raises 'tick' in the HALF_DIV-th cycle after
// the last clear. 'clr' restarts the count from zero.
// Assumes HALF_DIV >= 1. With HALF_DIV == 1 every cycle is a tick.
module bcs_tick #(
    parameter int HALF_DIV = 125
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    output logic tick
);

    localparam int CNT_W = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;

    generate
        if (HALF_DIV == 1) begin : g_every
            assign tick = 1'b1;
        end else begin : g_count
            localparam logic [CNT_W-1:0] LAST = CNT_W'(HALF_DIV - 1);
            logic [CNT_W-1:0] cnt_q;

            // Count up to LAST and wrap. A clear forces the next value to zero.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    cnt_q <= '0;
                end else if (clr || cnt_q == LAST) begin
                    cnt_q <= '0;
                end else begin
                    cnt_q <= cnt_q + 1'b1;
                end
            end

            assign tick = (cnt_q == LAST);
        end
    endgenerate

endmodule

// File: rtl/bcs_monitor.sv
// Bus condition monitor.
// It detects START (SDA falls while SCL stays high) and STOP (SDA rises
// while SCL stays high) from line samples, and keeps a busy flag that runs
// from a START to the next STOP.
// Assumes scl_i and sda_i are already synchronised to clk. While 'enable'
// is low the lines are ignored and the busy flag is cleared.
module bcs_monitor (
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic scl_i,
    input  logic sda_i,
    output logic start_p,
    output logic stop_p,
    output logic busy
);

    logic scl_prev;
    logic sda_prev;
    logic busy_q;

    // Compare the present line levels with the previous sample.
    always_comb begin
        start_p = enable & scl_i & scl_prev & sda_prev & ~sda_i;
        stop_p  = enable & scl_i & scl_prev & ~sda_prev & sda_i;
    end

    // Keep the previous sample and the busy flag. Disabled means idle lines.
    always_ff @(posedge clk) begin
        if (!rst_n || !enable) begin
            scl_prev <= 1'b1;
            sda_prev <= 1'b1;
            busy_q   <= 1'b0;
        end else begin
            scl_prev <= scl_i;
            sda_prev <= sda_i;
            if (start_p) begin
                busy_q <= 1'b1;
            end else if (stop_p) begin
                busy_q <= 1'b0;
            end
        end
    end

    assign busy = busy_q;

endmodule

// File: rtl/bcs_fsm.sv
// Condition sequencer state machine.
// It holds the start and stop request bits and steps through the line
// sequences for START, repeated START and STOP, one half-period per step.
// It asks the timer for a restart on every state change, during an SI
// stretch, and while a released SCL still reads low.
// Assumes 'tick' comes from a timer cleared by 'tick_clr', and 'busy' and
// 'stop_p' come from the bus monitor.
module bcs_fsm
    import bcs_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic tick,
    input  logic busy,
    input  logic stop_p,
    input  logic sta_set,
    input  logic sta_clr,
    input  logic sto_set,
    input  logic byte_done,
    input  logic si,
    input  logic scl_i,
    output logic scl_drv,
    output logic sda_drv,
    output logic master,
    output logic sta_q,
    output logic sto_q,
    output logic tick_clr
);

    seq_state_e state_q;
    seq_state_e state_d;
    logic       bytes_q;
    logic       sto_done;
    logic       hw_sta_clr;
    logic       not_master_st;

    // Next-state decision for the condition sequences.
    always_comb begin
        state_d  = state_q;
        sto_done = 1'b0;
        unique case (state_q)
            S_IDLE: begin
                if (sta_q) state_d = busy ? S_QUEUE : S_GAP;
            end
            S_QUEUE: begin
                if (!sta_q)     state_d = S_IDLE;
                else if (!busy) state_d = S_GAP;
            end
            S_GAP: begin
                if (!sta_q)     state_d = S_IDLE;
                else if (busy)  state_d = S_QUEUE;
                else if (tick)  state_d = S_STA_HI;
            end
            S_STA_HI: begin
                if (tick) state_d = S_HOLD;
            end
            S_HOLD: begin
                if (tick && !si) begin
                    if (sto_q)                 state_d = S_STP_SCL;
                    else if (sta_q && bytes_q) state_d = S_RS_SDA;
                end
            end
            S_STP_SCL: begin
                if (tick && scl_i) state_d = S_STP_SDA;
            end
            S_STP_SDA: begin
                if (stop_p) begin
                    sto_done = 1'b1;
                    state_d  = sta_q ? S_GAP : S_IDLE;
                end
            end
            S_RS_SDA: begin
                if (tick && !si) state_d = S_RS_SCL;
            end
            S_RS_SCL: begin
                if (tick && scl_i) state_d = S_STA_HI;
            end
            default: state_d = S_IDLE;
        endcase
        if (!enable) state_d = S_IDLE;
    end

    // Derived strobes: start bit clear, timer restart, non-owning states.
    always_comb begin
        hw_sta_clr    = (state_d == S_STA_HI) && (state_q != S_STA_HI);
        not_master_st = (state_q == S_IDLE) || (state_q == S_QUEUE) ||
                        (state_q == S_GAP);
        tick_clr      = (state_d != state_q) ||
                        (si && (state_q == S_HOLD || state_q == S_RS_SDA)) ||
                        (!scl_i && (state_q == S_STP_SCL || state_q == S_RS_SCL));
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // Start request bit: software clear wins, then set, then hardware clear.
    always_ff @(posedge clk) begin
        if (!rst_n)          sta_q <= 1'b0;
        else if (sta_clr)    sta_q <= 1'b0;
        else if (sta_set)    sta_q <= 1'b1;
        else if (hw_sta_clr) sta_q <= 1'b0;
    end

    // Stop request bit: held at zero when disabled, cleared by a seen stop
    // or, outside master states, right away as an internal stop.
    always_ff @(posedge clk) begin
        if (!rst_n || !enable)             sto_q <= 1'b0;
        else if (sto_set)                  sto_q <= 1'b1;
        else if (sto_done || not_master_st) sto_q <= 1'b0;
    end

    // Byte seen during the current master phase; reset on leaving it.
    always_ff @(posedge clk) begin
        if (!rst_n) bytes_q <= 1'b0;
        else        bytes_q <= (state_q == S_HOLD && state_d == S_HOLD) ?
                               (bytes_q | byte_done) : 1'b0;
    end

    // Line drive and ownership decode, all gated by enable.
    always_comb begin
        scl_drv = enable && (state_q == S_HOLD || state_q == S_RS_SDA);
        sda_drv = enable && (state_q == S_STA_HI || state_q == S_HOLD ||
                             state_q == S_STP_SCL);
        master  = enable && !not_master_st;
    end

endmodule

// File: rtl/bus_cond_seq.sv
// Top of the I2C master bus condition sequencer.
// It joins the half-period timer, the bus monitor and the sequencer state
// machine. Outputs are open-drain enables: 1 pulls the line low.
// Assumes scl_i/sda_i are synchronised and request inputs are one-cycle pulses.
module bus_cond_seq #(
    parameter int HALF_DIV = 125
) (
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic sta_set,
    input  logic sta_clr,
    input  logic sto_set,
    input  logic byte_done,
    input  logic si,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_oe,
    output logic sda_oe,
    output logic sta_bit,
    output logic sto_bit,
    output logic bus_busy,
    output logic master
);

    logic tick;
    logic tick_clr;
    logic start_p;
    logic stop_p;
    logic busy;
    logic sto_q;

    bcs_tick #(.HALF_DIV(HALF_DIV)) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (tick_clr),
        .tick  (tick)
    );

    bcs_monitor u_mon (
        .clk     (clk),
        .rst_n   (rst_n),
        .enable  (enable),
        .scl_i   (scl_i),
        .sda_i   (sda_i),
        .start_p (start_p),
        .stop_p  (stop_p),
        .busy    (busy)
    );

    bcs_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .enable    (enable),
        .tick      (tick),
        .busy      (busy),
        .stop_p    (stop_p),
        .sta_set   (sta_set),
        .sta_clr   (sta_clr),
        .sto_set   (sto_set),
        .byte_done (byte_done),
        .si        (si),
        .scl_i     (scl_i),
        .scl_drv   (scl_oe),
        .sda_drv   (sda_oe),
        .master    (master),
        .sta_q     (sta_bit),
        .sto_q     (sto_q),
        .tick_clr  (tick_clr)
    );

    // The stop bit reads as zero at once when the block is disabled.
    always_comb begin
        sto_bit  = enable & sto_q;
        bus_busy = busy;
    end

endmodule

// File: rtl/bcs_chk.sv
// Property checker for bus_cond_seq, attached with the bind below.
// It observes only ports of the top module.
module bcs_chk (
    input logic clk,
    input logic rst_n,
    input logic enable,
    input logic si,
    input logic sto_set,
    input logic scl_oe,
    input logic sda_oe,
    input logic sto_bit,
    input logic bus_busy,
    input logic master
);

    // R1/R2: a fresh START only follows a cycle in which the bus was free
    a_r1_start_on_free_bus: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(sda_oe) && !$past(master)) |-> (!$past(bus_busy) && !scl_oe));

    // R4: leaving the master role with a stop pending clears the stop bit
    a_r4_stop_clears_bit: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(master) && $past(sto_bit) && !$past(sto_set) && !master && enable)
        |-> !sto_bit);

    // R6: a stop bit outside the master role lasts one cycle
    a_r6_internal_stop: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(sto_bit) && !$past(master) && !$past(sto_set)) |-> !sto_bit);

    // R7: disabled means no drive, no ownership, no stop bit
    a_r7_disabled_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |-> (!scl_oe && !sda_oe && !sto_bit && !master));

    // R7: busy is dropped once the block has been disabled for a cycle
    a_r7_disabled_not_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (!enable && $past(!enable)) |-> !bus_busy);

    // R8: SCL stays pulled while SI remains set
    a_r8_si_stretch: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && $past(enable) && si && $past(si) && $past(scl_oe)) |-> scl_oe);

endmodule

bind bus_cond_seq bcs_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .enable   (enable),
    .si       (si),
    .sto_set  (sto_set),
    .scl_oe   (scl_oe),
    .sda_oe   (sda_oe),
    .sto_bit  (sto_bit),
    .bus_busy (bus_busy),
    .master   (master)
);

// File: tb/sim_bus_cond_seq.sv
// Bench for bus_cond_seq. It models the open-drain wires together with
// another master and a stretching slave, and times every edge against H.
module sim_bus_cond_seq;

    localparam int H = 4;
    localparam int W_SCL = 0, W_SDA = 1, W_MST = 2, W_STO = 3;
    localparam int P_STA = 0, P_STO = 1, P_BYTE = 2, P_CLR = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic enable = 1'b1;
    logic sta_set = 1'b0, sta_clr = 1'b0, sto_set = 1'b0, byte_done = 1'b0, si = 1'b0;
    logic ext_scl = 1'b0, ext_sda = 1'b0;
    logic scl_i, sda_i;
    logic scl_oe, sda_oe, sta_bit, sto_bit, bus_busy, master;

    int n_cmp = 0;
    int n_bad = 0;
    int n;

    always #10 clk = ~clk;

    assign scl_i = ~(scl_oe | ext_scl);
    assign sda_i = ~(sda_oe | ext_sda);

    bus_cond_seq #(.HALF_DIV(H)) u0 (
        .clk(clk), .rst_n(rst_n), .enable(enable),
        .sta_set(sta_set), .sta_clr(sta_clr), .sto_set(sto_set),
        .byte_done(byte_done), .si(si), .scl_i(scl_i), .sda_i(sda_i),
        .scl_oe(scl_oe), .sda_oe(sda_oe), .sta_bit(sta_bit), .sto_bit(sto_bit),
        .bus_busy(bus_busy), .master(master)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic win(input string req, input int got, input int lo, input int hi);
        chk(got >= lo && got <= hi, req, got, lo);
    endtask

    function automatic bit sig(input int w);
        case (w)
            W_SCL:   return scl_oe;
            W_SDA:   return sda_oe;
            W_MST:   return master;
            default: return sto_bit;
        endcase
    endfunction

    task automatic wait_until(input int w, input bit val, output int cnt);
        cnt = 0;
        while (sig(w) != val && cnt < 500) begin
            @(negedge clk);
            cnt++;
        end
    endtask

    task automatic pulse(input int w);
        case (w)
            P_STA:   sta_set = 1'b1;
            P_STO:   sto_set = 1'b1;
            P_BYTE:  byte_done = 1'b1;
            default: sta_clr = 1'b1;
        endcase
        @(negedge clk);
        sta_set = 1'b0; sto_set = 1'b0; byte_done = 1'b0; sta_clr = 1'b0;
    endtask

    task automatic quiet(input string req, input int cycles, input bit e_scl, input bit e_sda);
        int bad = 0;
        for (int i = 0; i < cycles; i++) begin
            @(negedge clk);
            if (scl_oe != e_scl || sda_oe != e_sda) bad++;
        end
        chk(bad == 0, req, {scl_oe, sda_oe}, {e_scl, e_sda});
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!scl_oe && !sda_oe && !master && !bus_busy && !sto_bit && !sta_bit,
            "R7 reset idle", {scl_oe, sda_oe, master, bus_busy}, 0);

        // R9 / R2: another master owns the bus; our start waits for its stop
        ext_sda = 1'b1;
        @(negedge clk);
        chk(bus_busy, "R9 external START sets busy", bus_busy, 1);
        pulse(P_STA);
        quiet("R2 queued START keeps lines released", 6 * H, 1'b0, 1'b0);
        ext_sda = 1'b0;
        wait_until(W_SDA, 1'b1, n);
        win("R2 START delay after STOP", n, H, H + 2);
        chk(!scl_oe, "R2 START made with SCL high", scl_oe, 0);
        wait_until(W_SCL, 1'b1, n);
        win("R1 START hold time", n, H, H + 1);
        chk(master && !sta_bit, "R1 master owned, STA cleared", {master, sta_bit}, 2);

        // R3: no repeated start without a finished byte, then the full sequence
        pulse(P_STA);
        quiet("R3 no repeated START before a byte", 3 * H, 1'b1, 1'b1);
        pulse(P_BYTE);
        wait_until(W_SDA, 1'b0, n);
        win("R3 SDA released first", n, 1, H + 2);
        chk(scl_oe, "R3 SCL still low at SDA release", scl_oe, 1);
        wait_until(W_SCL, 1'b0, n);
        win("R3 SCL released", n, H, H + 1);
        wait_until(W_SDA, 1'b1, n);
        win("R3 repeated START SDA fall", n, H, H + 1);
        chk(!scl_oe, "R3 repeated START with SCL high", scl_oe, 0);
        wait_until(W_SCL, 1'b1, n);
        win("R3 SCL pulled after repeated START", n, H, H + 1);
        chk(!sta_bit && bus_busy, "R3 STA cleared, bus stays busy", {sta_bit, bus_busy}, 1);

        // R8 / R4: SI stretches the low phase; stop follows after SI clears
        si = 1'b1;
        pulse(P_STO);
        quiet("R8 SCL held low while SI set", 5 * H, 1'b1, 1'b1);
        si = 1'b0;
        wait_until(W_SCL, 1'b0, n);
        win("R8 low phase resumes after SI", n, H, H + 1);
        chk(sda_oe, "R4 SDA held while SCL released", sda_oe, 1);
        si = 1'b1;
        wait_until(W_SDA, 1'b0, n);
        win("R8 high phase not stretched by SI", n, H, H + 1);
        @(negedge clk);
        chk(!sto_bit && !master, "R4 STO and master cleared after STOP", {sto_bit, master}, 0);
        chk(!bus_busy, "R9 own STOP clears busy", bus_busy, 0);
        si = 1'b0;

        // R1: start on a free bus
        pulse(P_STA);
        wait_until(W_SDA, 1'b1, n);
        win("R1 START from idle", n, H, H + 2);
        chk(!scl_oe, "R1 START with SCL high", scl_oe, 0);
        wait_until(W_SCL, 1'b1, n);
        win("R1 SCL pulled after START", n, H, H + 1);
        chk(master && bus_busy, "R9 own START sets busy", {master, bus_busy}, 3);

        // R5: both requests give a stop and then a start
        sta_set = 1'b1; sto_set = 1'b1;
        @(negedge clk);
        sta_set = 1'b0; sto_set = 1'b0;
        wait_until(W_SCL, 1'b0, n);
        win("R5 STOP begins", n, 1, H + 2);
        wait_until(W_SDA, 1'b0, n);
        win("R5 STOP SDA release", n, H, H + 1);
        wait_until(W_SDA, 1'b1, n);
        win("R5 START after bus-free gap", n, H, H + 2);
        chk(!scl_oe && !sto_bit && master, "R5 START follows STOP",
            {scl_oe, sto_bit, master}, 1);
        wait_until(W_SCL, 1'b1, n);
        win("R5 SCL pulled after START", n, H, H + 1);

        // R10: a slave stretches SCL during the stop; sweep the stretch length
        for (int k = 1; k <= 3; k++) begin
            ext_scl = 1'b1;
            pulse(P_STO);
            wait_until(W_SCL, 1'b0, n);
            quiet("R10 SDA held while SCL stretched", k * H, 1'b0, 1'b1);
            ext_scl = 1'b0;
            wait_until(W_SDA, 1'b0, n);
            win("R10 high phase counted from SCL rise", n, H, H + 1);
            @(negedge clk);
            chk(!master, "R10 stop completed", master, 0);
            pulse(P_STA);
            wait_until(W_SCL, 1'b1, n);
            chk(master, "R10 master again", master, 1);
        end

        // R7: disable while master
        enable = 1'b0;
        #1;
        chk(!scl_oe && !sda_oe && !master, "R7 disable releases lines",
            {scl_oe, sda_oe, master}, 0);
        @(negedge clk);
        pulse(P_STO);
        chk(!sto_bit, "R7 STO forced to 0 while disabled", sto_bit, 0);
        ext_sda = 1'b1;
        repeat (2) @(negedge clk);
        chk(!bus_busy, "R7 line activity ignored while disabled", bus_busy, 1'b0);
        ext_sda = 1'b0;
        @(negedge clk);
        enable = 1'b1;
        @(negedge clk);
        chk(!master && !bus_busy && !scl_oe && !sda_oe, "R7 idle after re-enable",
            {master, bus_busy, scl_oe, sda_oe}, 0);

        // R6: stop request while not master
        pulse(P_STO);
        chk(sto_bit, "R6 STO latched", sto_bit, 1);
        @(negedge clk);
        chk(!sto_bit, "R6 STO self-cleared outside master", sto_bit, 0);
        quiet("R6 internal STOP drives nothing", 2 * H, 1'b0, 1'b0);

        // R11: cancel a queued start
        ext_sda = 1'b1;
        @(negedge clk);
        pulse(P_STA);
        quiet("R11 queued while busy", 2 * H, 1'b0, 1'b0);
        pulse(P_CLR);
        chk(!sta_bit, "R11 STA cleared by software", sta_bit, 0);
        ext_sda = 1'b0;
        quiet("R11 cancelled START never issued", 4 * H, 1'b0, 1'b0);
        chk(!bus_busy && !master, "R11 bus free, not master", {bus_busy, master}, 0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule